// File: doc/BRIEF.md
# Double-Data-Rate DRAM Cache-Line Read Sequencer

This block is the read path of a memory controller. It fetches one 64-byte cache line at a time from a double-data-rate DRAM whose data interface is 8 bytes wide. The DRAM has a single bank and is not interleaved. Every fetch is treated as a row miss. After a request is taken, the sequencer spends one cycle of start-up overhead. It then precharges, opens the row, and issues one column read per clock. Each clock returns two double words, one on each DRAM clock edge, so four column reads cover the line.

The returned pairs are captured and driven onto the processor-side bus one cycle after they arrive. A single-cycle done flag marks the cycle that carries the last pair of the line. Because the command sequence never changes, the latency and the peak line rate are both fixed numbers. For a read latency of `CAS_LAT` cycles, both equal 8 + `CAS_LAT` cycles per line. Refresh and writes are not handled.

Top module: `ddr_line_fetch`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `dram_cmd` is idle (0), `dram_addr` is 0, and `fwd_valid` and `line_done` are 0.
- R2: After a request is taken at a clock edge, `dram_cmd` follows this order, one command per cycle: first idle (0) for one overhead cycle, then precharge (1), then activate (2), then exactly four consecutive column reads (3). The command is idle (0) after that.
- R3: During activate, `dram_addr` carries the row, which is request address bits [ADDR_W-1 : COL_W+3]. During the idle and precharge commands, `dram_addr` is 0.
- R4: The column reads put the double-word column on `dram_addr`. The base column is request bits [COL_W+2 : 3] with the three lowest column bits cleared. Read k (k = 0..3) uses base + 2k. Request bits [5:0] have no effect.
- R5: `dram_dq_pair` is sampled in the cycle `CAS_LAT` cycles after each column read. Its value appears on `fwd_data` with `fwd_valid` high in the following cycle, in read order. The lower 64 bits hold the rising-edge word and the upper 64 bits hold the falling-edge word.
- R6: `line_done` is high for exactly one cycle, together with the fourth forwarded pair. That cycle is cycle 8 + `CAS_LAT` after the accepting edge, counting the first cycle after that edge as cycle 1.
- R7: `req_valid` is ignored while a line is in flight, and so is the `req_addr` that comes with it. A request present in the cycle of `line_done` is taken, which makes the back-to-back period 8 + `CAS_LAT` cycles.
- R8: While idle with no request, `dram_cmd` stays idle (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and DRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line-read request |
| req_addr | input | ADDR_W (26) | Byte address of the line |
| dram_cmd | output | 2 | 0 idle, 1 precharge, 2 activate, 3 column read |
| dram_addr | output | ROW_W (13) | Row or column address |
| dram_dq_pair | input | 128 | Two double words returned in one clock (rising edge low, falling edge high) |
| fwd_data | output | 128 | Pair forwarded to the processor-side bus |
| fwd_valid | output | 1 | `fwd_data` holds a pair this cycle |
| line_done | output | 1 | Final pair of the line is forwarded this cycle |

## Verification
The bench tries four stimulus patterns:
- A lone one-cycle request shows the plain command order and latency.
- A request held high across several lines, with its address changing every cycle, separates correct latching and ignoring of busy-time requests from a design that restarts or re-samples the address. It also measures the back-to-back period.
- Addresses with nonzero line-offset bits, together with the all-ones address, show that the offset bits are masked and that the row and column fields are split correctly.
- The data pattern changes every cycle, so forwarding from the wrong cycle, or in the wrong order, is caught.

// File: rtl/ddr_lf_pkg.sv
`timescale 1ns/1ps
package ddr_lf_pkg;

    localparam int DQ_BYTES    = 8;
    localparam int LINE_BYTES  = 64;
    localparam int DW_PER_LINE = LINE_BYTES / DQ_BYTES;
    localparam int BEATS       = DW_PER_LINE / 2;
    localparam int BEAT_W      = $clog2(BEATS);
    localparam int BYTE_OFS_W  = $clog2(DQ_BYTES);
    localparam int LINE_DW_W   = $clog2(DW_PER_LINE);
    localparam int DQ_W        = DQ_BYTES * 8;
    localparam int PAIR_W      = 2 * DQ_W;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_RD  = 2'd3
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_PRE,
        ST_ACT,
        ST_READ,
        ST_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic issue;
        logic last;
    } rd_tag_t;

    function automatic logic [BEAT_W:0] beat_step(input logic [BEAT_W-1:0] beat);
        return {beat, 1'b0};
    endfunction

endpackage

// File: rtl/ddr_lf_seq.sv
`timescale 1ns/1ps
module ddr_lf_seq
    import ddr_lf_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int ADDR_W = ROW_W + COL_W + BYTE_OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              last_capture,
    output dram_cmd_e         cmd_o,
    output logic [ROW_W-1:0]  addr_o,
    output rd_tag_t           rd_tag_o
);

    localparam int COL_LO = BYTE_OFS_W;
    localparam int ROW_LO = BYTE_OFS_W + COL_W;

    seq_state_e              state_q;
    logic [BEAT_W-1:0]       beat_q;
    logic [ROW_W-1:0]        row_q;
    logic [COL_W-1:0]        col_base_q;
    logic                    final_beat;

    assign final_beat = (beat_q == BEAT_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            beat_q     <= '0;
            row_q      <= '0;
            col_base_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        row_q      <= req_addr[ADDR_W-1:ROW_LO];
                        col_base_q <= {req_addr[COL_LO+COL_W-1:COL_LO+LINE_DW_W],
                                       {LINE_DW_W{1'b0}}};
                        state_q    <= ST_START;
                    end
                end
                ST_START: state_q <= ST_PRE;
                ST_PRE:   state_q <= ST_ACT;
                ST_ACT: begin
                    beat_q  <= '0;
                    state_q <= ST_READ;
                end
                ST_READ: begin
                    beat_q <= beat_q + 1'b1;
                    if (final_beat) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (last_capture) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_o          = CMD_NOP;
        addr_o         = '0;
        rd_tag_o.issue = 1'b0;
        rd_tag_o.last  = 1'b0;
        case (state_q)
            ST_PRE: cmd_o = CMD_PRE;
            ST_ACT: begin
                cmd_o  = CMD_ACT;
                addr_o = row_q;
            end
            ST_READ: begin
                cmd_o              = CMD_RD;
                addr_o[COL_W-1:0]  = col_base_q | COL_W'(beat_step(beat_q));
                rd_tag_o.issue     = 1'b1;
                rd_tag_o.last      = final_beat;
            end
            default: ;
        endcase
    end

    assert_act_after_pre_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ACT) |-> ($past(cmd_o) == CMD_PRE));

    assert_rd_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_RD && $past(cmd_o) != CMD_RD) |-> ($past(cmd_o) == CMD_ACT));

    assert_rd_run_length_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_RD && $past(cmd_o) == CMD_RD) |->
        ($past(cmd_o, 4) == CMD_RD && $past(cmd_o, 5) == CMD_ACT));

    assert_pre_after_overhead_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_PRE) |-> ($past(cmd_o) == CMD_NOP && $past(cmd_o, 2) != CMD_PRE));

endmodule

// File: rtl/ddr_lf_capture.sv
`timescale 1ns/1ps
module ddr_lf_capture
    import ddr_lf_pkg::*;
#(
    parameter int CAS_LAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_tag_t           rd_tag_i,
    input  logic [PAIR_W-1:0] dq_pair_i,
    output logic              last_capture_o,
    output logic [PAIR_W-1:0] fwd_data_o,
    output logic              fwd_valid_o,
    output logic              done_o
);

    rd_tag_t pipe_q [CAS_LAT];
    logic    arriving;

    generate
        if (CAS_LAT == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe_q[0] <= '0;
                else     pipe_q[0] <= rd_tag_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int j = 0; j < CAS_LAT; j++) pipe_q[j] <= '0;
                end else begin
                    pipe_q[0] <= rd_tag_i;
                    for (int j = 1; j < CAS_LAT; j++) pipe_q[j] <= pipe_q[j-1];
                end
            end
        end
    endgenerate

    assign arriving       = pipe_q[CAS_LAT-1].issue;
    assign last_capture_o = arriving & pipe_q[CAS_LAT-1].last;

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_data_o  <= '0;
            fwd_valid_o <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            fwd_valid_o <= arriving;
            done_o      <= last_capture_o;
            if (arriving) fwd_data_o <= dq_pair_i;
        end
    end

    assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_with_data_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> fwd_valid_o);

    assert_data_held_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(arriving)) |-> $stable(fwd_data_o));

endmodule

// File: rtl/ddr_line_fetch.sv
`timescale 1ns/1ps
module ddr_line_fetch
    import ddr_lf_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int COL_W   = 10,
    parameter int CAS_LAT = 1,
    parameter int ADDR_W  = ROW_W + COL_W + BYTE_OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        dram_cmd,
    output logic [ROW_W-1:0]  dram_addr,
    input  logic [PAIR_W-1:0] dram_dq_pair,
    output logic [PAIR_W-1:0] fwd_data,
    output logic              fwd_valid,
    output logic              line_done
);

    dram_cmd_e cmd_w;
    rd_tag_t   rd_tag_w;
    logic      last_capture_w;

    ddr_lf_seq #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .last_capture(last_capture_w),
        .cmd_o       (cmd_w),
        .addr_o      (dram_addr),
        .rd_tag_o    (rd_tag_w)
    );

    ddr_lf_capture #(
        .CAS_LAT(CAS_LAT)
    ) u_capture (
        .clk           (clk),
        .rst           (rst),
        .rd_tag_i      (rd_tag_w),
        .dq_pair_i     (dram_dq_pair),
        .last_capture_o(last_capture_w),
        .fwd_data_o    (fwd_data),
        .fwd_valid_o   (fwd_valid),
        .done_o        (line_done)
    );

    assign dram_cmd = cmd_w;

    assert_addr_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd == 2'd0 || dram_cmd == 2'd1) |-> (dram_addr == '0));

    assert_done_idle_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        line_done |-> (dram_cmd == 2'd0));

    assert_valid_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fwd_valid) |-> ($past(dram_cmd, CAS_LAT + 1) == 2'd3));

endmodule

// File: tb/ddr_line_fetch_tb_top.sv
`timescale 1ns/1ps
module ddr_line_fetch_tb_top;

    localparam int ROW_W   = 13;
    localparam int COL_W   = 10;
    localparam int CL      = 1;
    localparam int ADDR_W  = ROW_W + COL_W + 3;
    localparam int PAIR_W  = 128;
    localparam int PERIOD  = 8 + CL;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        dram_cmd;
    logic [ROW_W-1:0]  dram_addr;
    logic [PAIR_W-1:0] dram_dq_pair = '0;
    logic [PAIR_W-1:0] fwd_data;
    logic              fwd_valid;
    logic              line_done;

    ddr_line_fetch #(.ROW_W(ROW_W), .COL_W(COL_W), .CAS_LAT(CL)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .dram_cmd(dram_cmd), .dram_addr(dram_addr), .dram_dq_pair(dram_dq_pair),
        .fwd_data(fwd_data), .fwd_valid(fwd_valid), .line_done(line_done)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // Behavioural reference: phase counts cycles since the accepting edge.
    int                phase = 0;
    int                acc_cyc = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic              e_valid = 1'b0;
    logic              e_done = 1'b0;
    logic [PAIR_W-1:0] e_data = '0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            phase = 0; e_valid = 1'b0; e_done = 1'b0; e_data = '0;
        end else begin
            e_valid = (phase >= 4 + CL) && (phase <= 7 + CL);
            if (e_valid) e_data = dram_dq_pair;
            e_done = (phase == 7 + CL);
            if ((phase == 0 || phase >= PERIOD) && req_valid) begin
                phase = 1; m_addr = req_addr; acc_cyc = cyc;
            end else if (phase != 0 && phase < PERIOD) begin
                phase = phase + 1;
            end
        end
    end

    function automatic logic [1:0] exp_cmd(input int p);
        if (p == 2) return 2'd1;
        if (p == 3) return 2'd2;
        if (p >= 4 && p <= 7) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [ROW_W-1:0] exp_addr(input int p, input logic [ADDR_W-1:0] a);
        int col;
        if (p == 3) return a[ADDR_W-1 -: ROW_W];
        if (p >= 4 && p <= 7) begin
            col = (int'(a[COL_W+2:3]) / 8) * 8 + 2 * (p - 4);
            return ROW_W'(col);
        end
        return '0;
    endfunction

    task automatic check(input string req, input string what, input logic [PAIR_W-1:0] act,
                         input logic [PAIR_W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    int  last_pre = -1;
    bit  b2b_mode = 1'b0;

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R2 R8", "dram_cmd", PAIR_W'(dram_cmd), PAIR_W'(exp_cmd(phase)));
            check(phase == 3 ? "R3" : "R4", "dram_addr", PAIR_W'(dram_addr),
                  PAIR_W'(exp_addr(phase, m_addr)));
            check("R5", "fwd_valid", PAIR_W'(fwd_valid), PAIR_W'(e_valid));
            if (e_valid) check("R5", "fwd_data", fwd_data, e_data);
            check("R6", "line_done", PAIR_W'(line_done), PAIR_W'(e_done));
            if (line_done) check("R6", "latency", PAIR_W'(cyc - acc_cyc + 1), PAIR_W'(PERIOD));
            if (dram_cmd == 2'd1) begin
                if (b2b_mode && last_pre >= 0)
                    check("R7", "back-to-back period", PAIR_W'(cyc - last_pre), PAIR_W'(PERIOD));
                last_pre = cyc;
            end
        end
        dram_dq_pair <= {cyc[31:0] ^ 32'h5A5A_0F0F, ~cyc[31:0], cyc[31:0] + 32'd7, cyc[31:0] * 3};
    end

    task automatic pulse(input logic [ADDR_W-1:0] a);
        @(negedge clk); req_valid = 1'b1; req_addr = a;
        @(negedge clk); req_valid = 1'b0; req_addr = ~a;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "cmd in reset", PAIR_W'(dram_cmd), '0);
        check("R1", "addr in reset", PAIR_W'(dram_addr), '0);
        check("R1", "valid/done in reset", PAIR_W'({fwd_valid, line_done}), '0);
        rst = 1'b0;
        repeat (6) @(negedge clk);      // R8: idle with no request
        pulse(26'h0ABCDEF);             // R4: nonzero offset bits ignored
        repeat (20) @(negedge clk);
        pulse(26'h1234540);
        repeat (3) @(negedge clk);
        pulse(26'h3000000);             // R7: lone request while busy
        repeat (20) @(negedge clk);
        // R7: request held high, address changing every cycle
        b2b_mode = 1'b1;
        last_pre = -1;
        @(negedge clk); req_valid = 1'b1;
        for (int i = 0; i < 5 * PERIOD; i++) begin
            req_addr = ADDR_W'((i * 32'h9E3779B1) ^ (i << 7));
            @(negedge clk);
        end
        req_valid = 1'b0;
        b2b_mode = 1'b0;
        repeat (20) @(negedge clk);
        pulse({ADDR_W{1'b1}});          // R3 R4: all-ones address
        repeat (20) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule